// File: doc/BRIEF.md
# Link Status LED Driver

This block turns the link state reported by an Ethernet PHY into drive levels for three indicator pins: a link lamp, a speed lamp and an activity/collision lamp. A mode input picks one of two meaning maps for the link and activity lamps. The speed lamp shows the line rate in both maps. Activity and collision events are single-cycle pulses. Each pulse starts a flash window. During that window the lamp shows the inverse of its resting state, so that even one short packet can be seen.

The pins also serve as configuration straps while the chip is in reset. For this reason the active level of each pin is not fixed. The block samples the level on each pin's strap input while reset is asserted and keeps that value afterwards. A pin that was pulled up is driven active-low, and a pin that was pulled down is driven active-high. Every output is registered and updates one clock after its inputs.

Top module: `led_status_drv`

## Requirements
- R1: While `rst` is high, each output equals its `strap_pol` bit (bit 0 link, bit 1 speed, bit 2 activity). That bit is held from the last reset cycle. After reset, each output equals lit XOR held bit, so a held 1 means active-low. Changes on `strap_pol` after reset have no effect.
- R2: When `link_up` was low in the previous cycle, all three outputs are at their inactive level, in either map.
- R3: With link up, the speed lamp is lit exactly when `spd_100` was high in the previous cycle, in both maps.
- R4: Map 0 (`map_sel`=0): with link up, the link lamp is lit steadily. The activity lamp is dark except during an activity flash window. Collision pulses have no effect on any lamp.
- R5: Map 1 (`map_sel`=1): with link up, the link lamp is lit and goes dark during an activity flash window.
- R6: Map 1: with link up, the activity lamp is lit when `full_dup` is high. A collision flash window inverts it.
- R7: A pulse accepted at clock edge k inverts its lamp for exactly STRETCH_CYC cycles, starting with the output update at edge k+1. A recovery phase follows. Pulses during the flash window or the recovery phase are ignored and do not restart it.
- R8: A free-running prescaler ticks once every PRESC_DIV cycles, counted from reset. The recovery phase ends at the ON_TICKS-th tick after the inverted phase ends.
- R9: Link down cancels any flash window or recovery phase at once. The first pulse after the link returns is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap sampling window |
| link_up | input | 1 | Link established |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_dup | input | 1 | 1 = full duplex |
| act_evt | input | 1 | Activity pulse |
| col_evt | input | 1 | Collision pulse |
| map_sel | input | 1 | Meaning map select |
| strap_pol | input | 3 | Strap levels: bit 0 link, 1 speed, 2 activity |
| led_link_o | output | 1 | Link lamp drive |
| led_spd_o | output | 1 | Speed lamp drive |
| led_act_o | output | 1 | Activity/collision lamp drive |

## Verification
The hardest case to reach is a pulse that arrives while the recovery phase is still running. That phase ends on a prescaler tick, so its length in cycles depends on where the free-running prescaler happens to stand. Directed sequences first re-pulse right after the inverted phase, and then drop the link in the middle of a window. Long random runs with dense activity and collision pulses, map changes and short link drops then land pulses at every prescaler offset. Every cycle is compared against a bench model written from the requirements.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;
  typedef struct packed {
    logic act;
    logic spd;
    logic link;
  } led_vec_t;
endpackage

// File: rtl/led_prescaler.sv
module led_prescaler #(
  parameter int PRESC_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R8
endmodule

// File: rtl/led_flash.sv
module led_flash #(
  parameter int STRETCH_CYC = 5,
  parameter int ON_TICKS    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic evt,
  input  logic tick,
  output logic flash
);
  localparam int MAXC = (STRETCH_CYC > ON_TICKS) ? STRETCH_CYC : ON_TICKS;
  localparam int CW   = $clog2(MAXC + 1);

  logic          busy_q;
  logic          inv_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy_q <= 1'b0;
      inv_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (evt) begin
        busy_q <= 1'b1;
        inv_q  <= 1'b1;
        cnt_q  <= CW'(STRETCH_CYC - 1);
      end
    end else if (inv_q) begin
      if (cnt_q == '0) begin
        inv_q <= 1'b0;
        cnt_q <= CW'(ON_TICKS);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (tick) begin
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
      else                 cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign flash = busy_q & inv_q;

  AST_FLASH_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(evt)); // R7
  AST_CLR_CANCELS: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> !busy_q); // R9
  AST_RECOVERY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_q) && !$past(clr)) |-> $past(tick)); // R8
endmodule

// File: rtl/led_map.sv
module led_map
  import led_drv_pkg::*;
(
  input  logic     link_up,
  input  logic     spd_100,
  input  logic     full_dup,
  input  logic     map_sel,
  input  logic     act_flash,
  input  logic     col_flash,
  output led_vec_t lit
);
  always_comb begin
    lit = '0;
    if (link_up) begin
      lit.spd = spd_100;
      if (map_sel) begin
        lit.link = ~act_flash;
        lit.act  = full_dup ^ col_flash;
      end else begin
        lit.link = 1'b1;
        lit.act  = act_flash;
      end
    end
  end
endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
  import led_drv_pkg::*;
#(
  parameter int PRESC_DIV   = 8,
  parameter int STRETCH_CYC = 5,
  parameter int ON_TICKS    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       link_up,
  input  logic       spd_100,
  input  logic       full_dup,
  input  logic       act_evt,
  input  logic       col_evt,
  input  logic       map_sel,
  input  logic [2:0] strap_pol,
  output logic       led_link_o,
  output logic       led_spd_o,
  output logic       led_act_o
);
  logic     tick;
  logic     act_flash;
  logic     col_flash;
  led_vec_t lit;
  led_vec_t pol_q;
  led_vec_t drv_q;

  led_prescaler #(.PRESC_DIV(PRESC_DIV)) presc_i (
    .clk(clk), .rst(rst), .tick(tick)
  );

  led_flash #(.STRETCH_CYC(STRETCH_CYC), .ON_TICKS(ON_TICKS)) act_fl_i (
    .clk(clk), .rst(rst), .clr(~link_up), .evt(act_evt), .tick(tick), .flash(act_flash)
  );

  led_flash #(.STRETCH_CYC(STRETCH_CYC), .ON_TICKS(ON_TICKS)) col_fl_i (
    .clk(clk), .rst(rst), .clr(~link_up), .evt(col_evt), .tick(tick), .flash(col_flash)
  );

  led_map map_i (
    .link_up(link_up), .spd_100(spd_100), .full_dup(full_dup), .map_sel(map_sel),
    .act_flash(act_flash), .col_flash(col_flash), .lit(lit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= led_vec_t'(strap_pol);
      drv_q <= led_vec_t'(strap_pol);
    end else begin
      drv_q <= lit ^ pol_q;
    end
  end

  assign led_link_o = drv_q.link;
  assign led_spd_o  = drv_q.spd;
  assign led_act_o  = drv_q.act;

  AST_POL_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(pol_q)); // R1
  AST_NOLINK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(link_up) |-> (drv_q == pol_q)); // R2
  AST_SPEED_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    ($past(link_up) && !$past(rst)) |-> (led_spd_o == ($past(spd_100) ^ pol_q.spd))); // R3
  AST_MAP0_LINK_STEADY: assert property (@(posedge clk) disable iff (rst)
    ($past(link_up) && !$past(map_sel) && !$past(rst)) |-> (led_link_o == ~pol_q.link)); // R4
endmodule

// File: tb/led_status_drv_tb_top.sv
module led_status_drv_tb_top;
  localparam int DIV = 8;
  localparam int STR = 5;
  localparam int ONT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_up = 1'b0, spd_100 = 1'b0, full_dup = 1'b0;
  logic act_evt = 1'b0, col_evt = 1'b0, map_sel = 1'b0;
  logic [2:0] strap_pol = 3'b000;
  logic led_link_o, led_spd_o, led_act_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  int m_pc = 0;
  bit [2:0] m_pol = 0, m_led = 0;
  bit fa_busy = 0, fa_inv = 0, fc_busy = 0, fc_inv = 0;
  int fa_cnt = 0, fc_cnt = 0;

  always #10 clk = ~clk;

  led_status_drv #(.PRESC_DIV(DIV), .STRETCH_CYC(STR), .ON_TICKS(ONT)) dut_i (
    .clk(clk), .rst(rst), .link_up(link_up), .spd_100(spd_100), .full_dup(full_dup),
    .act_evt(act_evt), .col_evt(col_evt), .map_sel(map_sel), .strap_pol(strap_pol),
    .led_link_o(led_link_o), .led_spd_o(led_spd_o), .led_act_o(led_act_o)
  );

  function automatic bit [2:0] exp_lit(bit lk, bit sp, bit fd, bit ms, bit af, bit cf);
    bit [2:0] l;
    l = 3'b000;
    if (lk) begin
      l[1] = sp;
      if (ms) begin l[0] = !af; l[2] = fd ^ cf; end
      else    begin l[0] = 1'b1; l[2] = af; end
    end
    return l;
  endfunction

  task automatic flash_step(inout bit busy, inout bit inv, inout int cnt, input bit ev, input bit tk);
    if (rst || !link_up) begin busy = 0; inv = 0; cnt = 0; end
    else if (!busy) begin
      if (ev) begin busy = 1; inv = 1; cnt = STR - 1; end
    end else if (inv) begin
      if (cnt == 0) begin inv = 0; cnt = ONT; end else cnt--;
    end else if (tk) begin
      if (cnt == 1) busy = 0; else cnt--;
    end
  endtask

  task automatic model_step();
    bit tk;
    tk = (m_pc == DIV - 1);
    if (rst) begin
      m_pol = strap_pol; m_led = strap_pol; m_pc = 0;
    end else begin
      m_led = exp_lit(link_up, spd_100, full_dup, map_sel, fa_busy & fa_inv, fc_busy & fc_inv) ^ m_pol;
      m_pc = tk ? 0 : m_pc + 1;
    end
    flash_step(fa_busy, fa_inv, fa_cnt, act_evt, tk);
    flash_step(fc_busy, fc_inv, fc_cnt, col_evt, tk);
  endtask

  task automatic check(input string tag, input bit act_v, input bit exp_v);
    n_vec++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // one clock: model update at the edge, compare at the following falling edge
  task automatic cyc();
    string tl, ta;
    @(posedge clk);
    model_step();
    @(negedge clk);
    tl = !link_up ? "R2" : (map_sel ? "R5" : "R4");
    ta = !link_up ? "R2" : (map_sel ? "R6" : "R4");
    if (rst) begin tl = "R1"; ta = "R1"; end
    check({tl, " link lamp"}, led_link_o, m_led[0]);
    check(rst ? "R1 speed lamp" : "R3 speed lamp", led_spd_o, m_led[1]);
    check({ta, " act lamp"}, led_act_o, m_led[2]);
  endtask

  task automatic pulse_act();
    act_evt = 1; cyc(); act_evt = 0;
  endtask

  // counts cycles the activity lamp is lit (map 0, link up) over n cycles
  task automatic count_act_lit(input int n, output int lit_n);
    lit_n = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (led_act_o != m_pol[2]) lit_n++;
    end
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int lit_n;
    void'($urandom(32'd1234));
    // R1: reset with mixed straps
    @(negedge clk);
    strap_pol = 3'b101; rst = 1;
    repeat (3) cyc();
    check("R1 reset link", led_link_o, 1'b1);
    check("R1 reset speed", led_spd_o, 1'b0);
    check("R1 reset act", led_act_o, 1'b1);
    rst = 0; strap_pol = 3'b010;   // R1: strap change after reset ignored
    link_up = 1; spd_100 = 1; map_sel = 0;
    cyc(); cyc();
    check("R1 active-low link lit", led_link_o, 1'b0);
    check("R3 speed lit at 100", led_spd_o, 1'b1);
    // R4/R7: one pulse lights the activity lamp for STRETCH cycles
    pulse_act();
    count_act_lit(STR + 2, lit_n);
    check("R7 flash length", lit_n == STR, 1'b1);
    // R7: pulse during recovery is ignored
    pulse_act();
    count_act_lit(4, lit_n);
    check("R7 no restart in recovery", lit_n == 0, 1'b1);
    repeat (3 * DIV) cyc();
    // R9: link drop cancels, next pulse accepted
    pulse_act(); cyc();
    link_up = 0; cyc();
    check("R2 no link act", led_act_o, m_pol[2]);
    link_up = 1; cyc();
    pulse_act();
    count_act_lit(STR + 2, lit_n);
    check("R9 pulse after relink", lit_n == STR, 1'b1);
    // R4: collision in map 0 has no effect
    col_evt = 1; cyc(); col_evt = 0;
    count_act_lit(STR + 2, lit_n);
    check("R4 collision ignored in map 0", lit_n == 0, 1'b1);
    // R6: map 1 full duplex with collision
    map_sel = 1; full_dup = 1;
    repeat (3 * DIV) cyc();
    check("R6 full duplex lit", led_act_o, 1'b0);
    col_evt = 1; cyc(); col_evt = 0; cyc();
    check("R6 collision inverts", led_act_o, 1'b1);
    // random phase, R5/R6/R7/R8 checked per cycle against the model
    for (int i = 0; i < 6000; i++) begin
      act_evt  = ($urandom_range(0, 99) < 15);
      col_evt  = ($urandom_range(0, 99) < 8);
      link_up  = ($urandom_range(0, 99) < 95);
      if ($urandom_range(0, 99) < 3) map_sel  = ~map_sel;
      if ($urandom_range(0, 99) < 3) full_dup = ~full_dup;
      if ($urandom_range(0, 99) < 3) spd_100  = ~spd_100;
      strap_pol = 3'($urandom);
      if (i == 3000) rst = 1;
      if (i == 3004) rst = 0;
      cyc();
    end
    act_evt = 0; col_evt = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule